// File: doc/BRIEF.md
# Four-Way Set-Associative Byte Cache

The block is a 4-way set-associative cache placed between a processor that issues single-byte reads and writes and a plain main-memory port. Memory is 20-bit byte-addressed. The cache holds 1024 lines of 8 bytes each, grouped as 256 sets of four ways. On every request the controller compares the tags of the four ways in the indexed set. A hit completes at once. A miss picks a way, fetches the whole line as eight byte beats, and then completes the request from the freshly filled line.

An invalid way is always filled first. Once a set is full, the victim is the way that has gone unreferenced longest. A 4-entry age ordering per set records this, and it is refreshed on every hit and every fill. The parameter `WRITE_BACK` selects the write policy:

- **Write-back (1):** a write touches only the cache and marks the way dirty. A dirty victim is copied to memory before the refill is read.
- **Write-through (0):** every write is also sent to memory as a single byte beat. A write that misses first allocates the line.

The processor must hold its request fields stable until it sees `cpu_ready`.

Top module: `cache_ctrl`

## Requirements
- R1: The address is split as tag = bits 19:11, set index = bits 10:3, byte offset = bits 2:0, so block j lives in set j mod 256. Address 0xABCDE falls in set 0x9B with offset 6 and tag 0x157, and its refill starts at 0xABCD8.
- R2: A read that hits asserts `cpu_ready` in the same cycle the request is presented, returns the stored byte on `cpu_rdata`, and causes no memory traffic.
- R3: A miss reads the line from memory as 8 beats at addresses {tag, set, 0} to {tag, set, 7} in ascending order. The access then completes with the requested byte.
- R4: After reset every way is invalid. A miss in a set that still has an invalid way fills that way, so four distinct tags in one set all stay resident.
- R5: A miss in a full set replaces the way whose last hit or fill is oldest.
- R6: With `WRITE_BACK`=0, every write completes in the cycle its single memory write beat is accepted. That beat carries the CPU address and byte.
- R7: With `WRITE_BACK`=1, a write hit causes no memory traffic. Evicting a written way first sends its 8 bytes to memory at {old tag, set, 0..7}, then reads the refill.
- R8: With `WRITE_BACK`=1, evicting a way that was never written since its fill causes no write beats.
- R9: `cpu_ready` stays low while a miss is being handled. A memory request keeps its address and direction until `mem_ready` accepts it.
- R10: After reset, `cpu_ready` and `mem_req` are low, and the first access to any address misses.
- R11: `cpu_ready` is only asserted while `cpu_req` is high, and memory is only requested on behalf of a held CPU request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | CPU access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 20 | Byte address |
| cpu_wdata | input | 8 | Write byte |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | 8 | Read byte, valid with `cpu_ready` on a read |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = memory write beat |
| mem_addr | output | 20 | Memory byte address of the beat |
| mem_wdata | output | 8 | Memory write byte |
| mem_ready | input | 1 | Memory accepts the beat this cycle |
| mem_rdata | input | 8 | Memory read byte, valid with `mem_ready` |

## Verification
Most corrupted internal states show up at the ports within one or two accesses to the affected set:

- **Tag or valid error:** shows as an unexpected refill (eight read beats) or a missing one.
- **Bad age ordering:** evicts the wrong way. The next access to the way that should have survived then refetches, so the miss count diverges at that access.
- **Lost or spurious dirty bit:** changes the write-beat count on the eviction itself. A lost write-back is also caught later, when refetched data differs from the last byte written.
- **Wrong line data or beat order:** appears as a wrong `cpu_rdata` on the first read of that byte.

// File: rtl/cache_pkg.sv
package cache_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WBACK = 2'd1,
      ST_FILL  = 2'd2,
      ST_WTHRU = 2'd3
   } cache_state_e;

endpackage

// File: rtl/cache_tag_store.sv
module cache_tag_store #(
   parameter int WAYS      = 4,
   parameter int SET_W     = 8,
   parameter int TAG_W     = 9,
   parameter bit HAS_DIRTY = 1'b1,
   localparam int SETS     = 1 << SET_W,
   localparam int WAY_W    = $clog2(WAYS)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [SET_W-1:0]            lk_set,
   input  logic [TAG_W-1:0]            lk_tag,
   output logic [WAYS-1:0]             hit_vec,
   output logic [WAYS-1:0]             valid_vec,
   output logic [WAYS-1:0]             dirty_vec,
   output logic [WAYS-1:0][TAG_W-1:0]  way_tag,
   input  logic                        fill_en,
   input  logic [WAY_W-1:0]            fill_way,
   input  logic                        mark_en,
   input  logic [WAY_W-1:0]            mark_way
);

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [TAG_W-1:0] tag_q [SETS];
      logic [SETS-1:0]  valid_q;
      logic             sel_fill;

      assign sel_fill = fill_en && (fill_way == WAY_W'(w));

      always_ff @(posedge clk) begin
         if (sel_fill) tag_q[lk_set] <= lk_tag;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        valid_q <= '0;
         else if (sel_fill) valid_q[lk_set] <= 1'b1;
      end

      assign way_tag[w]   = tag_q[lk_set];
      assign valid_vec[w] = valid_q[lk_set];
      assign hit_vec[w]   = valid_q[lk_set] && (tag_q[lk_set] == lk_tag);

      if (HAS_DIRTY) begin : g_dirty
         logic [SETS-1:0] dirty_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        dirty_q <= '0;
            else if (sel_fill) dirty_q[lk_set] <= 1'b0;
            else if (mark_en && (mark_way == WAY_W'(w)))
                               dirty_q[lk_set] <= 1'b1;
         end
         assign dirty_vec[w] = dirty_q[lk_set];
      end else begin : g_clean
         assign dirty_vec[w] = 1'b0;
      end
   end

endmodule

// File: rtl/cache_data_store.sv
module cache_data_store #(
   parameter int WAYS   = 4,
   parameter int SET_W  = 8,
   parameter int OFF_W  = 3,
   localparam int SETS  = 1 << SET_W,
   localparam int WAY_W = $clog2(WAYS),
   localparam int LINE_W = 8 << OFF_W
) (
   input  logic                        clk,
   input  logic [SET_W-1:0]            set_idx,
   output logic [WAYS-1:0][LINE_W-1:0] rd_lines,
   input  logic [WAY_W-1:0]            wr_way,
   input  logic                        line_we,
   input  logic [LINE_W-1:0]           wr_line,
   input  logic                        byte_we,
   input  logic [OFF_W-1:0]            wr_off,
   input  logic [7:0]                  wr_byte
);

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      logic [LINE_W-1:0] line_q [SETS];

      always_ff @(posedge clk) begin
         if (wr_way == WAY_W'(w)) begin
            if (line_we)      line_q[set_idx] <= wr_line;
            else if (byte_we) line_q[set_idx][{wr_off, 3'b000} +: 8] <= wr_byte;
         end
      end

      assign rd_lines[w] = line_q[set_idx];
   end

endmodule

// File: rtl/cache_lru.sv
module cache_lru #(
   parameter int WAYS   = 4,
   parameter int SET_W  = 8,
   localparam int SETS  = 1 << SET_W,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SET_W-1:0] set_idx,
   output logic [WAY_W-1:0] oldest_way,
   input  logic             touch_en,
   input  logic [WAY_W-1:0] touch_way
);

   // age 0 = most recent, WAYS-1 = least recent; each set holds a permutation
   logic [WAYS-1:0][WAY_W-1:0] age_q [SETS];
   logic [WAYS-1:0][WAY_W-1:0] cur_age, nxt_age;

   assign cur_age = age_q[set_idx];

   always_comb begin
      for (int w = 0; w < WAYS; w++) begin
         if (WAY_W'(w) == touch_way)
            nxt_age[w] = '0;
         else if (cur_age[w] < cur_age[touch_way])
            nxt_age[w] = cur_age[w] + 1'b1;
         else
            nxt_age[w] = cur_age[w];
      end
   end

   always_comb begin
      oldest_way = '0;
      for (int w = 0; w < WAYS; w++)
         if (cur_age[w] == WAY_W'(WAYS - 1)) oldest_way = WAY_W'(w);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++)
               age_q[s][w] <= WAY_W'(w);
      end else if (touch_en) begin
         age_q[set_idx] <= nxt_age;
      end
   end

endmodule

// File: rtl/cache_ctrl.sv
module cache_ctrl #(
   parameter int ADDR_W     = 20,
   parameter int SET_W      = 8,
   parameter int OFF_W      = 3,
   parameter int WAYS       = 4,
   parameter bit WRITE_BACK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [7:0]        cpu_wdata,
   output logic              cpu_ready,
   output logic [7:0]        cpu_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic              mem_ready,
   input  logic [7:0]        mem_rdata
);
   import cache_pkg::*;

   localparam int TAG_W  = ADDR_W - SET_W - OFF_W;
   localparam int WAY_W  = $clog2(WAYS);
   localparam int LINE_W = 8 << OFF_W;
   localparam logic [OFF_W-1:0] LAST_BEAT = '1;

   if (WAYS < 2 || (1 << WAY_W) != WAYS) begin : g_bad_ways
      $error("cache_ctrl: WAYS must be a power of two, at least 2");
   end
   if (TAG_W < 1 || OFF_W < 1 || SET_W < 1) begin : g_bad_split
      $error("cache_ctrl: address fields do not fit ADDR_W");
   end

   logic [TAG_W-1:0] req_tag;
   logic [SET_W-1:0] req_set;
   logic [OFF_W-1:0] req_off;
   assign req_tag = cpu_addr[ADDR_W-1 -: TAG_W];
   assign req_set = cpu_addr[OFF_W +: SET_W];
   assign req_off = cpu_addr[OFF_W-1:0];

   cache_state_e      state_q, state_d;
   logic [OFF_W-1:0]  beat_q;
   logic [WAY_W-1:0]  vict_q;
   logic [TAG_W-1:0]  vict_tag_q;
   logic [LINE_W-1:0] fbuf_q;

   logic [WAYS-1:0]             hit_vec, valid_vec, dirty_vec;
   logic [WAYS-1:0][TAG_W-1:0]  way_tag;
   logic [WAYS-1:0][LINE_W-1:0] lines;
   logic [WAY_W-1:0]            hit_way, inv_way, lru_way, miss_way, wr_way;
   logic                        hit, any_inv;
   logic                        fill_en, mark_en, line_we, byte_we, touch_en;
   logic [LINE_W-1:0]           fill_line;
   logic                        beat_go;

   cache_tag_store #(
      .WAYS(WAYS), .SET_W(SET_W), .TAG_W(TAG_W), .HAS_DIRTY(WRITE_BACK)
   ) i_tags (
      .clk(clk), .rst_n(rst_n), .lk_set(req_set), .lk_tag(req_tag),
      .hit_vec(hit_vec), .valid_vec(valid_vec), .dirty_vec(dirty_vec),
      .way_tag(way_tag), .fill_en(fill_en), .fill_way(vict_q),
      .mark_en(mark_en), .mark_way(hit_way)
   );

   cache_data_store #(
      .WAYS(WAYS), .SET_W(SET_W), .OFF_W(OFF_W)
   ) i_data (
      .clk(clk), .set_idx(req_set), .rd_lines(lines), .wr_way(wr_way),
      .line_we(line_we), .wr_line(fill_line), .byte_we(byte_we),
      .wr_off(req_off), .wr_byte(cpu_wdata)
   );

   cache_lru #(
      .WAYS(WAYS), .SET_W(SET_W)
   ) i_lru (
      .clk(clk), .rst_n(rst_n), .set_idx(req_set), .oldest_way(lru_way),
      .touch_en(touch_en), .touch_way(wr_way)
   );

   always_comb begin
      hit     = 1'b0;
      hit_way = '0;
      for (int w = 0; w < WAYS; w++)
         if (hit_vec[w]) begin
            hit     = 1'b1;
            hit_way = WAY_W'(w);
         end
      any_inv = 1'b0;
      inv_way = '0;
      for (int w = WAYS - 1; w >= 0; w--)
         if (!valid_vec[w]) begin
            any_inv = 1'b1;
            inv_way = WAY_W'(w);
         end
   end

   assign miss_way  = any_inv ? inv_way : lru_way;
   assign wr_way    = (state_q == ST_FILL) ? vict_q : hit_way;
   assign cpu_rdata = lines[hit_way][{req_off, 3'b000} +: 8];
   assign beat_go   = mem_req && mem_ready;

   always_comb begin
      fill_line = fbuf_q;
      fill_line[LINE_W-1 -: 8] = mem_rdata;
   end

   always_comb begin
      state_d   = state_q;
      cpu_ready = 1'b0;
      mem_req   = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = {req_tag, req_set, beat_q};
      mem_wdata = '0;
      fill_en   = 1'b0;
      mark_en   = 1'b0;
      line_we   = 1'b0;
      byte_we   = 1'b0;
      touch_en  = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (cpu_req) begin
               if (hit) begin
                  if (!cpu_we) begin
                     cpu_ready = 1'b1;
                     touch_en  = 1'b1;
                  end else if (WRITE_BACK) begin
                     cpu_ready = 1'b1;
                     touch_en  = 1'b1;
                     byte_we   = 1'b1;
                     mark_en   = 1'b1;
                  end else begin
                     state_d = ST_WTHRU;
                  end
               end else if (WRITE_BACK && valid_vec[miss_way] && dirty_vec[miss_way]) begin
                  state_d = ST_WBACK;
               end else begin
                  state_d = ST_FILL;
               end
            end
         end
         ST_WBACK: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = {vict_tag_q, req_set, beat_q};
            mem_wdata = lines[vict_q][{beat_q, 3'b000} +: 8];
            if (mem_ready && beat_q == LAST_BEAT) state_d = ST_FILL;
         end
         ST_FILL: begin
            mem_req = 1'b1;
            if (mem_ready && beat_q == LAST_BEAT) begin
               line_we  = 1'b1;
               fill_en  = 1'b1;
               touch_en = 1'b1;
               state_d  = ST_IDLE;
            end
         end
         ST_WTHRU: begin
            mem_req   = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = cpu_addr;
            mem_wdata = cpu_wdata;
            if (mem_ready) begin
               cpu_ready = 1'b1;
               byte_we   = 1'b1;
               touch_en  = 1'b1;
               state_d   = ST_IDLE;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         beat_q     <= '0;
         vict_q     <= '0;
         vict_tag_q <= '0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && cpu_req && !hit) begin
            beat_q     <= '0;
            vict_q     <= miss_way;
            vict_tag_q <= way_tag[miss_way];
         end else if (beat_go && (state_q == ST_WBACK || state_q == ST_FILL)) begin
            beat_q <= beat_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (state_q == ST_FILL && mem_ready)
         fbuf_q[{beat_q, 3'b000} +: 8] <= mem_rdata;
   end

endmodule

// File: rtl/cache_ctrl_chk.sv
module cache_ctrl_chk #(
   parameter int ADDR_W     = 20,
   parameter int OFF_W      = 3,
   parameter bit WRITE_BACK = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req,
   input logic              cpu_we,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic [7:0]        cpu_wdata,
   input logic              cpu_ready,
   input logic              mem_req,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [7:0]        mem_wdata,
   input logic              mem_ready
);

   // R11
   ready_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_ready |-> cpu_req);

   // R11
   mem_needs_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> cpu_req);

   // R9
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));

   // R9
   miss_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_we |-> !cpu_ready);

   // R3
   beat_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_ready && (WRITE_BACK || !mem_we) && (mem_addr[OFF_W-1:0] != '1)
      |=> mem_req && (mem_addr[OFF_W-1:0] == OFF_W'($past(mem_addr[OFF_W-1:0]) + 1'b1)));

   if (WRITE_BACK) begin : g_wb
      // R7
      wb_hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cpu_ready && cpu_we |-> !mem_req);
   end else begin : g_wt
      // R6
      wt_write_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
         cpu_ready && cpu_we |-> mem_req && mem_we && mem_ready
                                 && mem_addr == cpu_addr && mem_wdata == cpu_wdata);
   end

endmodule

bind cache_ctrl cache_ctrl_chk #(
   .ADDR_W(ADDR_W), .OFF_W(OFF_W), .WRITE_BACK(WRITE_BACK)
) i_chk (
   .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
   .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
   .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
   .mem_wdata(mem_wdata), .mem_ready(mem_ready)
);

// File: tb/test_cache_ctrl.sv
module test_cache_ctrl;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic        cpu_req [2];
   logic        cpu_we [2];
   logic [19:0] cpu_addr [2];
   logic [7:0]  cpu_wdata [2];
   logic        cpu_ready [2];
   logic [7:0]  cpu_rdata [2];
   logic        mem_req [2];
   logic        mem_we [2];
   logic [19:0] mem_addr [2];
   logic [7:0]  mem_wdata [2];
   logic        mem_ready [2];
   logic [7:0]  mem_rdata [2];

   // index 0: write-back, index 1: write-through
   cache_ctrl #(.WRITE_BACK(1'b1)) i_cache_ctrl (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req[0]), .cpu_we(cpu_we[0]),
      .cpu_addr(cpu_addr[0]), .cpu_wdata(cpu_wdata[0]), .cpu_ready(cpu_ready[0]),
      .cpu_rdata(cpu_rdata[0]), .mem_req(mem_req[0]), .mem_we(mem_we[0]),
      .mem_addr(mem_addr[0]), .mem_wdata(mem_wdata[0]), .mem_ready(mem_ready[0]),
      .mem_rdata(mem_rdata[0]));

   cache_ctrl #(.WRITE_BACK(1'b0)) i_cache_ctrl_wt (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req[1]), .cpu_we(cpu_we[1]),
      .cpu_addr(cpu_addr[1]), .cpu_wdata(cpu_wdata[1]), .cpu_ready(cpu_ready[1]),
      .cpu_rdata(cpu_rdata[1]), .mem_req(mem_req[1]), .mem_we(mem_we[1]),
      .mem_addr(mem_addr[1]), .mem_wdata(mem_wdata[1]), .mem_ready(mem_ready[1]),
      .mem_rdata(mem_rdata[1]));

   int total = 0;
   int bad = 0;

   bit [7:0] mem [int];
   bit [7:0] shadow [int];
   int rd_cnt [2];
   int wr_cnt [2];
   logic [19:0] first_rd [2];
   logic [19:0] first_wr [2];

   int m_tag [2][256][4];
   bit m_val [2][256][4];
   bit m_dty [2][256][4];
   int m_age [2][256][4];

   function automatic logic [7:0] pat(int a);
      return 8'((a * 37) ^ (a >> 7) ^ 8'h5A);
   endfunction

   function automatic logic [7:0] mem_rd(int d, int a);
      int key = (d << 20) | a;
      return mem.exists(key) ? mem[key] : pat(a);
   endfunction

   function automatic logic [7:0] view_rd(int d, int a);
      int key = (d << 20) | a;
      return shadow.exists(key) ? shadow[key] : pat(a);
   endfunction

   function automatic void chk(bit ok, string rq, int act, int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endfunction

   function automatic void touch(int d, int s, int w);
      int a = m_age[d][s][w];
      for (int i = 0; i < 4; i++) begin
         if (i == w) m_age[d][s][i] = 0;
         else if (m_age[d][s][i] < a) m_age[d][s][i]++;
      end
   endfunction

   // memory model: ready pattern and read data set away from the rising edge
   always @(negedge clk) begin
      for (int d = 0; d < 2; d++) begin
         mem_ready[d] = ($urandom % 10) < 7;
         mem_rdata[d] = mem_rd(d, int'(mem_addr[d]));
      end
   end

   always @(posedge clk) begin
      for (int d = 0; d < 2; d++) begin
         if (rst_n && mem_req[d] && mem_ready[d]) begin
            if (mem_we[d]) begin
               mem[(d << 20) | int'(mem_addr[d])] = mem_wdata[d];
               if (wr_cnt[d] == 0) first_wr[d] = mem_addr[d];
               wr_cnt[d]++;
            end else begin
               if (rd_cnt[d] == 0) first_rd[d] = mem_addr[d];
               rd_cnt[d]++;
            end
         end
      end
   end

   task automatic access(int d, logic [19:0] a, bit we, logic [7:0] wd);
      int s = int'(a[10:3]);
      int t = int'(a[19:11]);
      int hw = -1;
      int vw = -1;
      int exp_rd = 0, exp_wr = 0, exp_wb = 0, vtag = 0, cyc = 0;
      bit had_inv = 0;
      logic [7:0] exp_data, got;
      for (int w = 0; w < 4; w++)
         if (m_val[d][s][w] && m_tag[d][s][w] == t) hw = w;
      if (hw >= 0) begin
         touch(d, s, hw);
         if (we && d == 0) m_dty[d][s][hw] = 1;
         if (we && d == 1) exp_wr = 1;
      end else begin
         for (int w = 3; w >= 0; w--)
            if (!m_val[d][s][w]) begin vw = w; had_inv = 1; end
         if (vw < 0)
            for (int w = 0; w < 4; w++) if (m_age[d][s][w] == 3) vw = w;
         if (d == 0 && m_val[d][s][vw] && m_dty[d][s][vw]) begin
            exp_wb = 8; vtag = m_tag[d][s][vw];
         end
         exp_rd = 8;
         m_tag[d][s][vw] = t; m_val[d][s][vw] = 1; m_dty[d][s][vw] = 0;
         touch(d, s, vw);
         if (we && d == 0) m_dty[d][s][vw] = 1;
         if (we && d == 1) exp_wr = 1;
      end
      exp_wr += exp_wb;
      exp_data = view_rd(d, int'(a));
      if (we) shadow[(d << 20) | int'(a)] = wd;

      @(negedge clk);
      rd_cnt[d] = 0; wr_cnt[d] = 0;
      cpu_req[d] = 1; cpu_we[d] = we; cpu_addr[d] = a; cpu_wdata[d] = wd;
      #1;
      while (!cpu_ready[d] && cyc < 400) begin
         @(negedge clk); #1; cyc++;
      end
      chk(cyc < 400, "R9 access timeout", cyc, 400);
      got = cpu_rdata[d];
      @(posedge clk); #1;
      cpu_req[d] = 0;
      #1;
      chk(cpu_ready[d] == 1'b0, "R11 ready without request", int'(cpu_ready[d]), 0);
      chk(rd_cnt[d] == exp_rd, hw >= 0 ? "R2 hit read beats" : (had_inv ? "R4 fill beats" : "R5 victim fill beats"),
          rd_cnt[d], exp_rd);
      chk(wr_cnt[d] == exp_wr, d == 1 ? "R6 write beats" : (exp_wb != 0 ? "R7 write beats" : "R8 write beats"),
          wr_cnt[d], exp_wr);
      if (!we) chk(got == exp_data, hw >= 0 ? "R2 read data" : "R3 miss data", int'(got), int'(exp_data));
      if (hw >= 0 && !we) chk(cyc == 0, "R2 hit latency", cyc, 0);
      if (exp_rd != 0) begin
         chk(first_rd[d] == {a[19:3], 3'b000}, "R3 refill start", int'(first_rd[d]), int'({a[19:3], 3'b000}));
         chk(cyc >= exp_rd + exp_wb, "R9 ready during miss", cyc, exp_rd + exp_wb);
      end
      if (exp_wb != 0)
         chk(first_wr[d] == {9'(vtag), a[10:3], 3'b000}, "R7 writeback address",
             int'(first_wr[d]), int'({9'(vtag), a[10:3], 3'b000}));
      if (d == 1 && we && exp_wb == 0)
         chk(first_wr[d] == (hw >= 0 ? a : a), "R6 write address", int'(first_wr[d]), int'(a));
   endtask

   function automatic logic [19:0] mk(int t, int s, int o);
      return {9'(t), 8'(s), 3'(o)};
   endfunction

   initial begin
      #(1_500_000);
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h1c0ffee));
      for (int d = 0; d < 2; d++) begin
         cpu_req[d] = 0; cpu_we[d] = 0; cpu_addr[d] = '0; cpu_wdata[d] = '0;
         mem_ready[d] = 0; mem_rdata[d] = '0; rd_cnt[d] = 0; wr_cnt[d] = 0;
         for (int s = 0; s < 256; s++)
            for (int w = 0; w < 4; w++) begin
               m_val[d][s][w] = 0; m_dty[d][s][w] = 0; m_age[d][s][w] = w; m_tag[d][s][w] = 0;
            end
      end
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk(cpu_ready[0] == 0 && mem_req[0] == 0, "R10 reset outputs", int'(mem_req[0]), 0);
      chk(cpu_ready[1] == 0 && mem_req[1] == 0, "R10 reset outputs wt", int'(mem_req[1]), 0);

      // R1: 0xABCDE lands in set 0x9B, tag 0x157; refill starts at 0xABCD8
      access(0, 20'hABCDE, 0, 8'h00);
      chk(first_rd[0] == 20'hABCD8, "R1 split", int'(first_rd[0]), 20'hABCD8);
      chk(rd_cnt[0] == 8, "R10 first access misses", rd_cnt[0], 8);
      access(0, 20'hABCDE, 0, 8'h00);

      // R4 / R5: four tags fill set 0x9B, then LRU replacement
      access(0, mk(1, 8'h9B, 0), 0, 0);
      access(0, mk(2, 8'h9B, 1), 0, 0);
      access(0, mk(3, 8'h9B, 2), 0, 0);
      access(0, mk(9'h157, 8'h9B, 3), 0, 0);
      access(0, mk(1, 8'h9B, 4), 0, 0);
      access(0, mk(2, 8'h9B, 5), 0, 0);
      access(0, mk(4, 8'h9B, 6), 0, 0);
      access(0, mk(3, 8'h9B, 7), 0, 0);
      access(0, mk(1, 8'h9B, 0), 0, 0);

      // R7 / R8: dirty line written back before refill, data survives
      access(0, mk(5, 8'h21, 2), 1, 8'hC3);
      access(0, mk(6, 8'h21, 0), 0, 0);
      access(0, mk(7, 8'h21, 0), 0, 0);
      access(0, mk(8, 8'h21, 0), 0, 0);
      access(0, mk(10, 8'h21, 0), 0, 0);
      access(0, mk(5, 8'h21, 2), 0, 0);

      // R6: write-through hit and miss
      access(1, 20'hABCDE, 1, 8'h3C);
      access(1, 20'hABCDE, 1, 8'h77);
      access(1, 20'hABCDE, 0, 0);

      for (int i = 0; i < 700; i++) begin
         int d = i & 1;
         int r = $urandom % 4;
         int s = (r == 0) ? 8'h9B : (r == 1) ? 8'h21 : (r == 2) ? 8'h44 : int'($urandom % 256);
         int t = int'($urandom % 6);
         access(d, mk(t, s, int'($urandom % 8)), ($urandom % 10) < 4, 8'($urandom));
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule